// File: doc/BRIEF.md
# Watchdog Timer with Shared Binary Scaler

This block is a watchdog timer that counts on its own free-running clock, so it keeps timing while the system clock is stopped. A base counter produces a terminal-count pulse each time it wraps. A binary scaler of seven bits is shared with a general-purpose timer. One configuration bit gives the scaler either to the watchdog, where it stretches the timeout as a postscaler, or to the general timer, where it divides that timer's count events as a prescaler. A 3-bit select picks the division ratio from eight scaler taps.

A timeout has one of two results, depending on whether the device is asleep. While the device is awake, the timeout raises a one-cycle reset pulse in the system clock domain. While the device is asleep, it raises a one-cycle wake-up pulse in the watchdog clock domain, and no reset. Every timeout clears a timeout status flag. Software sets the flag again with a clear strobe.

Clear and sleep strobes come from the system clock domain. They cross into the watchdog domain over a request/acknowledge handshake. A strobe that arrives while an earlier one is still crossing is held and sent afterwards. Timeout events cross back as toggles. The assignment bit and the ratio select are treated as static configuration and are sampled directly. The general-timer count events on `tmr_tick` are single-cycle enables that are already synchronous to the watchdog clock.

Top module: `wdt_core`

## Requirements
- R1: With `scl_to_wdt` = 0 and the watchdog enabled, a timeout occurs once every 2^CNT_W watchdog clock cycles, whatever the value of `scl_sel`.
- R2: With `scl_to_wdt` = 1, a timeout occurs once every 2^CNT_W * 2^`scl_sel` watchdog clock cycles. Select values 0 to 7 give postscale ratios 1, 2, 4, ..., 128.
- R3: With `scl_to_wdt` = 0, `tmr_scaled_o` pulses once per 2^`scl_sel` cycles with `tmr_tick` high. With `scl_to_wdt` = 1, `tmr_scaled_o` follows `tmr_tick` undivided.
- R4: A timeout while `sleeping` is 0 gives exactly one `dev_rst_o` pulse, one system cycle wide, and no `wake_o` pulse.
- R5: A timeout while `sleeping` is 1 gives exactly one `wake_o` pulse, one watchdog cycle wide, and no `dev_rst_o` pulse.
- R6: `to_flag_o` is 1 after reset. Every timeout, whether it resets or wakes, clears `to_flag_o` to 0.
- R7: A `clr_stb` pulse sets `to_flag_o` to 1 on the next system clock edge. A timeout event that lands in the same cycle takes priority.
- R8: Each `clr_stb` or `sleep_stb` pulse restarts the base counter from 0. Strobes repeated faster than the timeout period prevent every timeout.
- R9: A strobe also clears the scaler count when `scl_to_wdt` = 1. When `scl_to_wdt` = 0, a strobe leaves the general timer's division untouched, and the assignment bit is never changed.
- R10: While `wdt_en` is 0, no timeout occurs and the base counter is held at 0. After `wdt_en` returns to 1, the first timeout comes one full base period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may be stopped during sleep |
| wdt_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| scl_to_wdt | input | 1 | Scaler assignment: 1 = watchdog postscaler, 0 = timer prescaler |
| scl_sel | input | SEL_W | Scaler tap select, ratio 2^scl_sel |
| clr_stb | input | 1 | Clear-watchdog strobe (system domain) |
| sleep_stb | input | 1 | Enter-sleep strobe (system domain) |
| sleeping | input | 1 | Sleep-state level from power management |
| tmr_tick | input | 1 | General timer count event (watchdog domain) |
| dev_rst_o | output | 1 | Device reset pulse (system domain) |
| wake_o | output | 1 | Wake-up pulse (watchdog domain) |
| to_flag_o | output | 1 | Timeout status flag, 0 after a timeout |
| tmr_scaled_o | output | 1 | Scaled count event to the general timer |

## Verification
The bench builds the block with CNT_W = 4 and the default SEL_W = 3. A base period of 16 watchdog cycles lets every one of the eight postscale ratios be measured exactly, up to 2048 cycles, together with the prescaler ratios on the timer path. The short period also makes timeouts frequent enough to check, within a short run, the reset-versus-wake choice, the flag behaviour, and the restart and scaler-clear effects of the strobes. The two clocks have unrelated periods, so the handshake and toggle crossings are exercised at varying phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned MASK_MAX = 32;

  // Mask with the n lowest bits set (n below MASK_MAX)
  function automatic logic [MASK_MAX-1:0] low_ones(input int unsigned n);
    logic [MASK_MAX-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MASK_MAX; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_sync_bit.sv
module wdt_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_req_bridge.sv
// Carries strobes from one clock domain to another with a toggle request
// and a returned acknowledge; strobes arriving while busy are held.
module wdt_req_bridge #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic stb_i,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse_o
);
  logic req_q, req_d, pend_q, pend_d, ack_s;
  logic req_s, seen_q;
  logic want, idle;

  wdt_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_s)
  );

  assign idle = (ack_s == req_q);
  assign want = pend_q | stb_i;

  always_comb begin
    req_d  = req_q ^ (idle & want);
    pend_d = want & ~idle;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  wdt_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) seen_q <= 1'b0;
    else            seen_q <= req_s;
  end

  assign pulse_o = req_s ^ seen_q;
endmodule

// File: rtl/wdt_scaler.sv
// Binary scaler: emits one pulse per 2^sel count enables.
module wdt_scaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_o
);
  localparam int SC_W = (1 << SEL_W) - 1;

  logic [SC_W-1:0] cnt_q, cnt_d, mask;

  assign mask  = SC_W'(wdt_pkg::low_ones(32'(sel)));
  assign tap_o = cnt_en & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             wdt_clk,
  input  logic             rst_n,
  input  logic             wdt_en,
  input  logic             scl_to_wdt,
  input  logic [SEL_W-1:0] scl_sel,
  input  logic             clr_stb,
  input  logic             sleep_stb,
  input  logic             sleeping,
  input  logic             tmr_tick,
  output logic             dev_rst_o,
  output logic             wake_o,
  output logic             to_flag_o,
  output logic             tmr_scaled_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic wrst_n, srst_n;
  logic restart_w, en_w, asleep_w;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic base_tc, scl_evt, scl_clr, scl_tap, timeout_w;
  logic wake_q, wake_d, rst_tgl_q, rst_tgl_d, wake_tgl_q, wake_tgl_d;
  logic rst_tgl_s, wake_tgl_s, rst_seen_q, wake_seen_q;
  logic rst_evt_s, wake_evt_s;
  logic dev_rst_q, to_q, to_d;

  // ---------------- reset release per domain ----------------
  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_w (
    .clk(wdt_clk), .arst_n(rst_n), .rst_n_o(wrst_n)
  );
  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_s (
    .clk(sys_clk), .arst_n(rst_n), .rst_n_o(srst_n)
  );

  // ---------------- crossings into the watchdog domain ----------------
  wdt_req_bridge #(.STAGES(SYNC_STAGES)) u_restart_br (
    .src_clk(sys_clk), .src_rst_n(srst_n), .stb_i(clr_stb | sleep_stb),
    .dst_clk(wdt_clk), .dst_rst_n(wrst_n), .pulse_o(restart_w)
  );
  wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk(wdt_clk), .rst_n(wrst_n), .d(wdt_en), .q(en_w)
  );
  wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sleep_sync (
    .clk(wdt_clk), .rst_n(wrst_n), .d(sleeping), .q(asleep_w)
  );

  // ---------------- base timeout counter ----------------
  always_comb begin
    if (!en_w || restart_w) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign base_tc = en_w & ~restart_w & (cnt_q == CNT_LAST);

  // ---------------- shared scaler and routing ----------------
  assign scl_evt = scl_to_wdt ? base_tc : tmr_tick;
  assign scl_clr = restart_w & scl_to_wdt;

  wdt_scaler #(.SEL_W(SEL_W)) u_scaler (
    .clk(wdt_clk), .rst_n(wrst_n), .cnt_en(scl_evt), .clr(scl_clr),
    .sel(scl_sel), .tap_o(scl_tap)
  );

  assign timeout_w    = scl_to_wdt ? scl_tap : base_tc;
  assign tmr_scaled_o = scl_to_wdt ? tmr_tick : scl_tap;

  // ---------------- timeout dispatch (watchdog domain) ----------------
  always_comb begin
    wake_d     = timeout_w & asleep_w;
    rst_tgl_d  = rst_tgl_q ^ (timeout_w & ~asleep_w);
    wake_tgl_d = wake_tgl_q ^ wake_d;
  end

  always_ff @(posedge wdt_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt_q      <= '0;
      wake_q     <= 1'b0;
      rst_tgl_q  <= 1'b0;
      wake_tgl_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      wake_q     <= wake_d;
      rst_tgl_q  <= rst_tgl_d;
      wake_tgl_q <= wake_tgl_d;
    end
  end

  assign wake_o = wake_q;

  // ---------------- events into the system domain ----------------
  wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_evt_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(rst_tgl_q), .q(rst_tgl_s)
  );
  wdt_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_evt_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(wake_tgl_q), .q(wake_tgl_s)
  );

  assign rst_evt_s  = rst_tgl_s ^ rst_seen_q;
  assign wake_evt_s = wake_tgl_s ^ wake_seen_q;

  always_comb begin
    to_d = to_q;
    if (rst_evt_s || wake_evt_s) to_d = 1'b0;
    else if (clr_stb)            to_d = 1'b1;
  end

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      rst_seen_q  <= 1'b0;
      wake_seen_q <= 1'b0;
      dev_rst_q   <= 1'b0;
      to_q        <= 1'b1;
    end else begin
      rst_seen_q  <= rst_tgl_s;
      wake_seen_q <= wake_tgl_s;
      dev_rst_q   <= rst_evt_s;
      to_q        <= to_d;
    end
  end

  assign dev_rst_o = dev_rst_q;
  assign to_flag_o = to_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 8
) (
  input logic             wdt_clk,
  input logic             sys_clk,
  input logic             wrst_n,
  input logic             srst_n,
  input logic             en_w,
  input logic             timeout_w,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wake_o,
  input logic             dev_rst_o,
  input logic             to_flag_o,
  input logic             clr_stb,
  input logic             rst_evt_s,
  input logic             wake_evt_s
);
  AST_OFF_NO_TIMEOUT: assert property (@(posedge wdt_clk) disable iff (!wrst_n)
    !en_w |-> !timeout_w); // R10
  AST_OFF_CNT_HELD: assert property (@(posedge wdt_clk) disable iff (!wrst_n)
    !en_w |=> (cnt_q == '0)); // R10
  AST_WAKE_SINGLE: assert property (@(posedge wdt_clk) disable iff (!wrst_n)
    wake_o |=> !wake_o); // R5
  AST_RST_SINGLE: assert property (@(posedge sys_clk) disable iff (!srst_n)
    dev_rst_o |=> !dev_rst_o); // R4
  AST_RST_CLEARS_TO: assert property (@(posedge sys_clk) disable iff (!srst_n)
    dev_rst_o |-> !to_flag_o); // R6
  AST_CLR_SETS_TO: assert property (@(posedge sys_clk) disable iff (!srst_n)
    (clr_stb && !rst_evt_s && !wake_evt_s) |=> to_flag_o); // R7
endmodule

bind wdt_core wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .wdt_clk(wdt_clk), .sys_clk(sys_clk), .wrst_n(wrst_n), .srst_n(srst_n),
  .en_w(en_w), .timeout_w(timeout_w), .cnt_q(cnt_q), .wake_o(wake_o),
  .dev_rst_o(dev_rst_o), .to_flag_o(to_flag_o), .clr_stb(clr_stb),
  .rst_evt_s(rst_evt_s), .wake_evt_s(wake_evt_s)
);

// File: tb/wdt_core_tb_top.sv
`timescale 1ns/1ps
module wdt_core_tb_top;
  localparam int TB_CNT_W = 4;
  localparam int TB_SEL_W = 3;
  localparam int NV = 11;
  localparam int WD_LIMIT = 190000;

  // vectors: {assign, select}, expected watchdog period, expected timer ratio
  localparam logic [3:0] V_CFG [NV] = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD,
                                        4'hE, 4'hF, 4'h0, 4'h3, 4'h7};
  localparam int V_WDT [NV] = '{16, 32, 64, 128, 256, 512, 1024, 2048, 16, 16, 16};
  localparam int V_TMR [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 8, 128};

  logic sys_clk = 1'b0, wdt_clk = 1'b0;
  logic rst_n, wdt_en, scl_to_wdt, clr_stb, sleep_stb, sleeping, tmr_tick;
  logic [TB_SEL_W-1:0] scl_sel;
  logic dev_rst_o, wake_o, to_flag_o, tmr_scaled_o;

  int checks = 0, failures = 0;
  int rst_cnt = 0, wake_cnt = 0, long_rst = 0, long_wake = 0;
  logic rst_prev = 1'b0, wake_prev = 1'b0;
  bit done = 1'b0;

  always #5 sys_clk = ~sys_clk;
  always #17 wdt_clk = ~wdt_clk;

  wdt_core #(.CNT_W(TB_CNT_W), .SEL_W(TB_SEL_W), .SYNC_STAGES(2)) dut_i (
    .sys_clk(sys_clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .wdt_en(wdt_en),
    .scl_to_wdt(scl_to_wdt), .scl_sel(scl_sel), .clr_stb(clr_stb),
    .sleep_stb(sleep_stb), .sleeping(sleeping), .tmr_tick(tmr_tick),
    .dev_rst_o(dev_rst_o), .wake_o(wake_o), .to_flag_o(to_flag_o),
    .tmr_scaled_o(tmr_scaled_o)
  );

  always @(negedge sys_clk) begin
    if (dev_rst_o) rst_cnt++;
    if (dev_rst_o && rst_prev) long_rst++;
    rst_prev = dev_rst_o;
  end

  always @(negedge wdt_clk) begin
    if (wake_o) wake_cnt++;
    if (wake_o && wake_prev) long_wake++;
    wake_prev = wake_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic measure_wake(output int n);
    int c;
    do @(negedge wdt_clk); while (!wake_o);
    c = 0;
    do begin @(negedge wdt_clk); c++; end while (!wake_o);
    n = c;
  endtask

  task automatic measure_tmr(output int n);
    int c;
    do @(negedge wdt_clk); while (!tmr_scaled_o);
    c = 0;
    do begin @(negedge wdt_clk); c++; end while (!tmr_scaled_o);
    n = c;
  endtask

  task automatic pulse_clr();
    @(negedge sys_clk); clr_stb = 1'b1;
    @(negedge sys_clk); clr_stb = 1'b0;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge sys_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in run actual=%0d expected=%0d", WD_LIMIT, 0);
      finish_up();
    end
  end

  initial begin
    int a, b, r0, w0;
    rst_n = 1'b0; wdt_en = 1'b1; scl_to_wdt = 1'b1; scl_sel = '0;
    clr_stb = 1'b0; sleep_stb = 1'b0; sleeping = 1'b1; tmr_tick = 1'b1;
    repeat (6) @(negedge sys_clk);
    // R6: reset state
    check(to_flag_o == 1'b1, "R6 flag after reset", to_flag_o, 1);
    check(dev_rst_o == 1'b0, "R4 no reset pulse in reset", dev_rst_o, 0);
    check(wake_o == 1'b0, "R5 no wake pulse in reset", wake_o, 0);
    rst_n = 1'b1;

    // vector table, asleep: periods of the watchdog and the timer path
    r0 = rst_cnt;
    for (int i = 0; i < NV; i++) begin
      @(negedge sys_clk);
      scl_to_wdt = V_CFG[i][3];
      scl_sel    = V_CFG[i][2:0];
      measure_wake(a); measure_wake(a);
      if (V_CFG[i][3]) check(a == V_WDT[i], "R2 postscaled period", a, V_WDT[i]);
      else             check(a == V_WDT[i], "R1 base period", a, V_WDT[i]);
      measure_tmr(b); measure_tmr(b);
      check(b == V_TMR[i], "R3 timer ratio", b, V_TMR[i]);
    end
    check(rst_cnt == r0, "R5 no reset while asleep", rst_cnt - r0, 0);
    check(long_wake == 0, "R5 wake width", long_wake, 0);
    check(to_flag_o == 1'b0, "R6 flag cleared by wake", to_flag_o, 0);

    // awake timeouts: R4
    @(negedge sys_clk);
    scl_to_wdt = 1'b0; scl_sel = 3'd2; sleeping = 1'b0;
    repeat (8) @(negedge wdt_clk);
    r0 = rst_cnt; w0 = wake_cnt;
    repeat (160) @(negedge wdt_clk);
    check((rst_cnt - r0) >= 9 && (rst_cnt - r0) <= 11, "R4 reset count", rst_cnt - r0, 10);
    check(wake_cnt == w0, "R4 no wake while awake", wake_cnt - w0, 0);
    check(long_rst == 0, "R4 reset width", long_rst, 0);
    check(to_flag_o == 1'b0, "R6 flag cleared by reset", to_flag_o, 0);

    // R7: clear strobe sets the flag right after a reset pulse
    do @(negedge sys_clk); while (!dev_rst_o);
    pulse_clr();
    check(to_flag_o == 1'b1, "R7 clear sets flag", to_flag_o, 1);

    // R8: repeated clears keep the watchdog quiet
    r0 = rst_cnt;
    repeat (300) begin
      pulse_clr();
      repeat (2) @(negedge sys_clk);
    end
    check(rst_cnt == r0, "R8 clears prevent reset", rst_cnt - r0, 0);
    check(to_flag_o == 1'b1, "R8 flag kept", to_flag_o, 1);

    // R8: repeated sleep strobes also restart the count
    sleeping = 1'b1;
    repeat (6) @(negedge wdt_clk);
    w0 = wake_cnt;
    repeat (300) begin
      @(negedge sys_clk); sleep_stb = 1'b1;
      @(negedge sys_clk); sleep_stb = 1'b0;
      repeat (2) @(negedge sys_clk);
    end
    check(wake_cnt == w0, "R8 sleep strobes prevent wake", wake_cnt - w0, 0);

    // R9: with the scaler on the timer, a clear does not disturb its division
    @(negedge sys_clk); scl_to_wdt = 1'b0; scl_sel = 3'd3;
    for (int k = 0; k < 3; k++) begin
      int c;
      do @(negedge wdt_clk); while (!tmr_scaled_o);
      c = 0;
      pulse_clr();
      do begin @(negedge wdt_clk); c++; end while (!tmr_scaled_o);
      check(c == 8, "R9 timer ratio across clear", c, 8);
    end

    // R9: with the scaler on the watchdog, a clear restarts the postscale
    @(negedge sys_clk); scl_to_wdt = 1'b1; scl_sel = 3'd2;
    measure_wake(a);
    repeat (40) @(negedge wdt_clk);
    pulse_clr();
    a = 0;
    do begin @(negedge wdt_clk); a++; end while (!wake_o);
    check(a >= 64 && a <= 72, "R9 scaler cleared by strobe", a, 68);
    check(scl_to_wdt == 1'b1, "R9 assignment kept", scl_to_wdt, 1);
    measure_wake(a);
    check(a == 64, "R9 period after clear", a, 64);

    // R10: disabled watchdog never times out
    @(negedge sys_clk); scl_to_wdt = 1'b0; wdt_en = 1'b0;
    repeat (6) @(negedge wdt_clk);
    r0 = rst_cnt; w0 = wake_cnt;
    sleeping = 1'b0;
    repeat (203) @(negedge wdt_clk);
    sleeping = 1'b1;
    repeat (203) @(negedge wdt_clk);
    check(rst_cnt == r0, "R10 no reset when disabled", rst_cnt - r0, 0);
    check(wake_cnt == w0, "R10 no wake when disabled", wake_cnt - w0, 0);
    wdt_en = 1'b1;
    a = 0;
    do begin @(negedge wdt_clk); a++; end while (!wake_o);
    check(a >= 16 && a <= 22, "R10 count restarts from zero", a, 18);

    finish_up();
  end
endmodule